// File: doc/BRIEF.md
# Mask Register Logic Unit

This block is an execution unit for a small file of 64-bit mask registers. Each accepted operation reads up to two mask registers. It computes a bitwise, arithmetic, shift, concatenation or test result at an operand width of 8, 16, 32 or 64 bits. The result is written back to a destination mask register, or it updates a zero flag and a carry flag. Move operations bring data in from a general-register value or a memory load word. Other move operations send a mask register out on a general-register result port or on a store data port.

The unit accepts one operation per clock cycle while `op_valid` is high. The operation takes effect on that rising edge. Every write is truncated to the selected width and zero-extended to 64 bits. The only exception is unpack, which writes a double-width result. Instruction decode, address generation and exceptions belong to the surrounding pipeline.

Top module: `mask_logic_unit`

## Requirements
- R1: Width code 0, 1, 2 or 3 selects 8, 16, 32 or 64 bits. Only source bits below the selected width affect any result or flag.
- R2: After every mask register write, all destination bits above the result width are zero. The result width is the selected width, or twice that width for unpack.
- R3: Opcodes 1 AND, 2 AND-NOT (first source inverted), 3 OR, 4 XOR, 5 XNOR and 6 NOT (first source) write the bitwise result of source a and source b to the destination.
- R4: Opcode 0 adds the two sources modulo 2 to the power of the width, with no carry-out indication.
- R5: Opcode 10 (or-test) writes no register. It sets zf when (a OR b) is all zero within the width, and cf when (a OR b) is all ones within the width.
- R6: Opcode 11 (test) writes no register. It sets zf when (a AND b) is zero, and cf when ((NOT a) AND b) is zero, within the width.
- R7: Opcode 9 (unpack) with width codes 0 to 2 writes {a[n-1:0], b[n-1:0]}, with source a in the upper half. With width code 3 it leaves the destination unchanged.
- R8: Opcodes 7 (shift left) and 8 (shift right) shift the width-truncated source a by the 8-bit immediate. A count at or above the width gives zero.
- R9: Opcode 12 copies mask register a, 13 loads `gpr_in`, and 14 loads `mem_rdata` into the destination. Opcode 15 places register a on `gpr_out`. Opcode 16 places register a on `mem_wdata` and pulses `mem_wr` for one cycle. All of these truncate to the width and zero-extend.
- R10: XNOR with the same register as destination and both sources sets every bit within the width to one.
- R11: Effects appear one edge after an accepted operation. With `op_valid` low, nothing changes. zf and cf change only on test and or-test operations.
- R12: Reset clears all mask registers, zf, cf, `gpr_out`, `mem_wdata` and `mem_wr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| op_valid | input | 1 | Operation accepted on this rising edge |
| op_code | input | 5 | Operation select |
| op_width | input | 2 | Width code: 0=8, 1=16, 2=32, 3=64 bits |
| dst_idx | input | IDX_W | Destination mask register |
| srca_idx | input | IDX_W | First source mask register |
| srcb_idx | input | IDX_W | Second source mask register |
| imm8 | input | 8 | Shift count |
| gpr_in | input | 64 | General-register source value |
| mem_rdata | input | 64 | Memory load word |
| gpr_out | output | 64 | General-register result, held until the next move-out |
| mem_wdata | output | 64 | Store data |
| mem_wr | output | 1 | Store strobe, high for one cycle |
| zf | output | 1 | Zero flag |
| cf | output | 1 | Carry flag |

## Verification
The bench builds the unit with its default of eight mask registers, so IDX_W is 3. Eight registers leave room for two staging sources, a result register and separate registers for the self-XNOR, flag and move cases. Register contents are read back only through the general-register move-out at 64-bit width. That readback makes the cleared upper bits and the untouched destinations visible at the ports.

// File: rtl/mku_pkg.sv
package mku_pkg;
  localparam int unsigned KW = 64;

  typedef enum logic [4:0] {
    OP_ADD  = 5'd0,  OP_AND  = 5'd1,  OP_ANDN = 5'd2,  OP_OR   = 5'd3,
    OP_XOR  = 5'd4,  OP_XNOR = 5'd5,  OP_NOT  = 5'd6,  OP_SHL  = 5'd7,
    OP_SHR  = 5'd8,  OP_UNPK = 5'd9,  OP_ORT  = 5'd10, OP_TST  = 5'd11,
    OP_MOVK = 5'd12, OP_LDG  = 5'd13, OP_LDM  = 5'd14, OP_STG  = 5'd15,
    OP_STM  = 5'd16
  } mku_op_e;

  typedef enum logic [1:0] {W8 = 2'd0, W16 = 2'd1, W32 = 2'd2, W64 = 2'd3} mku_width_e;

  function automatic int unsigned width_bits(mku_width_e w);
    return 32'd8 << w;
  endfunction

  function automatic logic [KW-1:0] width_mask(mku_width_e w);
    logic [KW-1:0] m;
    case (w)
      W8:      m = 64'h0000_0000_0000_00FF;
      W16:     m = 64'h0000_0000_0000_FFFF;
      W32:     m = 64'h0000_0000_FFFF_FFFF;
      default: m = '1;
    endcase
    return m;
  endfunction

  // Joins two n-bit fields into a 2n-bit value, first operand on top.
  function automatic logic [KW-1:0] unpack_join(mku_width_e w, logic [KW-1:0] hi,
                                                logic [KW-1:0] lo);
    logic [KW-1:0] r;
    case (w)
      W8:      r = {48'b0, hi[7:0], lo[7:0]};
      W16:     r = {32'b0, hi[15:0], lo[15:0]};
      W32:     r = {hi[31:0], lo[31:0]};
      default: r = '0;
    endcase
    return r;
  endfunction

  function automatic logic [KW-1:0] shift_clip(mku_width_e w, logic [KW-1:0] v,
                                               logic [7:0] n, logic left);
    logic [KW-1:0] r;
    if (32'(n) >= width_bits(w)) r = '0;
    else if (left)               r = (v << n) & width_mask(w);
    else                         r = v >> n;
    return r;
  endfunction
endpackage

// File: rtl/mku_regfile.sv
module mku_regfile #(
  parameter int unsigned NUM_REGS = 8,
  localparam int unsigned IDX_W = $clog2(NUM_REGS)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   we,
  input  logic [IDX_W-1:0]       waddr,
  input  logic [mku_pkg::KW-1:0] wdata,
  input  logic [IDX_W-1:0]       raddr_a,
  input  logic [IDX_W-1:0]       raddr_b,
  output logic [mku_pkg::KW-1:0] rdata_a,
  output logic [mku_pkg::KW-1:0] rdata_b
);
  logic [mku_pkg::KW-1:0] kreg [NUM_REGS];

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_entry
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                           kreg[i] <= '0;
      else if (we && waddr == IDX_W'(i))    kreg[i] <= wdata;
    end
  end

  assign rdata_a = kreg[raddr_a];
  assign rdata_b = kreg[raddr_b];

  assert_write_lands_R11: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> kreg[$past(waddr)] == $past(wdata));
endmodule

// File: rtl/mku_alu.sv
module mku_alu
  import mku_pkg::*;
(
  input  mku_op_e        op,
  input  mku_width_e     w,
  input  logic [KW-1:0]  a,
  input  logic [KW-1:0]  b,
  input  logic [7:0]     imm,
  input  logic [KW-1:0]  gpr_in,
  input  logic [KW-1:0]  mem_rdata,
  output logic [KW-1:0]  res,
  output logic [KW-1:0]  out_val,
  output logic           k_we,
  output logic           flag_we,
  output logic           zf_next,
  output logic           cf_next,
  output logic           gpr_we,
  output logic           mem_we
);
  logic [KW-1:0] mask, ta, tb;

  assign mask    = width_mask(w);
  assign ta      = a & mask;
  assign tb      = b & mask;
  assign out_val = ta;

  always_comb begin
    res     = '0;
    k_we    = 1'b0;
    flag_we = 1'b0;
    zf_next = 1'b0;
    cf_next = 1'b0;
    gpr_we  = 1'b0;
    mem_we  = 1'b0;
    case (op)
      OP_ADD:  begin res = (ta + tb) & mask;   k_we = 1'b1; end
      OP_AND:  begin res = ta & tb;            k_we = 1'b1; end
      OP_ANDN: begin res = ~ta & tb;           k_we = 1'b1; end
      OP_OR:   begin res = ta | tb;            k_we = 1'b1; end
      OP_XOR:  begin res = ta ^ tb;            k_we = 1'b1; end
      OP_XNOR: begin res = ~(ta ^ tb) & mask;  k_we = 1'b1; end
      OP_NOT:  begin res = ~ta & mask;         k_we = 1'b1; end
      OP_SHL:  begin res = shift_clip(w, ta, imm, 1'b1); k_we = 1'b1; end
      OP_SHR:  begin res = shift_clip(w, ta, imm, 1'b0); k_we = 1'b1; end
      OP_UNPK: begin res = unpack_join(w, ta, tb); k_we = (w != W64); end
      OP_ORT: begin
        flag_we = 1'b1;
        zf_next = ((ta | tb) == '0);
        cf_next = ((ta | tb) == mask);
      end
      OP_TST: begin
        flag_we = 1'b1;
        zf_next = ((ta & tb) == '0);
        cf_next = ((~ta & tb) == '0);
      end
      OP_MOVK: begin res = ta;               k_we = 1'b1; end
      OP_LDG:  begin res = gpr_in & mask;    k_we = 1'b1; end
      OP_LDM:  begin res = mem_rdata & mask; k_we = 1'b1; end
      OP_STG:  gpr_we = 1'b1;
      OP_STM:  mem_we = 1'b1;
      default: ;
    endcase
  end
endmodule

// File: rtl/mku_outreg.sv
module mku_outreg
  import mku_pkg::*;
(
  input  logic           clk,
  input  logic           rst_n,
  input  logic           flag_write,
  input  logic           zf_next,
  input  logic           cf_next,
  input  logic           gpr_write,
  input  logic           mem_write,
  input  logic [KW-1:0]  out_val,
  output logic [KW-1:0]  gpr_out,
  output logic [KW-1:0]  mem_wdata,
  output logic           mem_wr,
  output logic           zf,
  output logic           cf
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gpr_out   <= '0;
      mem_wdata <= '0;
      mem_wr    <= 1'b0;
      zf        <= 1'b0;
      cf        <= 1'b0;
    end else begin
      mem_wr <= mem_write;
      if (gpr_write)  gpr_out   <= out_val;
      if (mem_write)  mem_wdata <= out_val;
      if (flag_write) begin
        zf <= zf_next;
        cf <= cf_next;
      end
    end
  end

  assert_flags_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !flag_write |=> $stable({zf, cf}));

  assert_store_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    mem_write |=> mem_wr && mem_wdata == $past(out_val));
endmodule

// File: rtl/mask_logic_unit.sv
module mask_logic_unit
  import mku_pkg::*;
#(
  parameter int unsigned NUM_REGS = 8,
  localparam int unsigned IDX_W = $clog2(NUM_REGS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              op_valid,
  input  logic [4:0]        op_code,
  input  logic [1:0]        op_width,
  input  logic [IDX_W-1:0]  dst_idx,
  input  logic [IDX_W-1:0]  srca_idx,
  input  logic [IDX_W-1:0]  srcb_idx,
  input  logic [7:0]        imm8,
  input  logic [63:0]       gpr_in,
  input  logic [63:0]       mem_rdata,
  output logic [63:0]       gpr_out,
  output logic [63:0]       mem_wdata,
  output logic              mem_wr,
  output logic              zf,
  output logic              cf
);
  mku_op_e    op;
  mku_width_e wsel;
  logic [KW-1:0] src_a, src_b, alu_res, out_val;
  logic alu_k_we, alu_flag_we, alu_gpr_we, alu_mem_we, zf_next, cf_next;
  logic k_write, flag_write, gpr_write, mem_write;

  assign op   = mku_op_e'(op_code);
  assign wsel = mku_width_e'(op_width);

  mku_regfile #(.NUM_REGS(NUM_REGS)) u_rf (
    .clk(clk), .rst_n(rst_n), .we(k_write), .waddr(dst_idx), .wdata(alu_res),
    .raddr_a(srca_idx), .raddr_b(srcb_idx), .rdata_a(src_a), .rdata_b(src_b)
  );

  mku_alu u_alu (
    .op(op), .w(wsel), .a(src_a), .b(src_b), .imm(imm8), .gpr_in(gpr_in),
    .mem_rdata(mem_rdata), .res(alu_res), .out_val(out_val), .k_we(alu_k_we),
    .flag_we(alu_flag_we), .zf_next(zf_next), .cf_next(cf_next),
    .gpr_we(alu_gpr_we), .mem_we(alu_mem_we)
  );

  assign k_write    = op_valid & alu_k_we;
  assign flag_write = op_valid & alu_flag_we;
  assign gpr_write  = op_valid & alu_gpr_we;
  assign mem_write  = op_valid & alu_mem_we;

  mku_outreg u_out (
    .clk(clk), .rst_n(rst_n), .flag_write(flag_write), .zf_next(zf_next),
    .cf_next(cf_next), .gpr_write(gpr_write), .mem_write(mem_write),
    .out_val(out_val), .gpr_out(gpr_out), .mem_wdata(mem_wdata),
    .mem_wr(mem_wr), .zf(zf), .cf(cf)
  );

  assert_upper_clear_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (k_write && op != OP_UNPK) |-> (alu_res & ~width_mask(wsel)) == '0);

  assert_xnor_ones_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op == OP_XNOR && srca_idx == srcb_idx) |-> alu_res == width_mask(wsel));

  assert_tests_nowrite_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && (op == OP_ORT || op == OP_TST)) |-> !k_write && flag_write);

  assert_unpack_wide_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op == OP_UNPK && wsel == W64) |-> !k_write);

  assert_shift_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && (op == OP_SHL || op == OP_SHR) && 32'(imm8) >= width_bits(wsel))
      |-> alu_res == '0);
endmodule

// File: tb/mask_logic_unit_test.sv
module mask_logic_unit_test;
  localparam int IW = 3;

  logic clk = 1'b0, rst_n = 1'b0, op_valid = 1'b0;
  logic [4:0] op_code = '0;
  logic [1:0] op_width = '0;
  logic [IW-1:0] dst_idx = '0, srca_idx = '0, srcb_idx = '0;
  logic [7:0] imm8 = '0;
  logic [63:0] gpr_in = '0, mem_rdata = '0;
  logic [63:0] gpr_out, mem_wdata;
  logic mem_wr, zf, cf;
  int checks = 0, fails = 0;

  always #2.5 clk = ~clk;

  mask_logic_unit #(.NUM_REGS(8)) uut (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
    .op_width(op_width), .dst_idx(dst_idx), .srca_idx(srca_idx),
    .srcb_idx(srcb_idx), .imm8(imm8), .gpr_in(gpr_in), .mem_rdata(mem_rdata),
    .gpr_out(gpr_out), .mem_wdata(mem_wdata), .mem_wr(mem_wr), .zf(zf), .cf(cf)
  );

  typedef struct packed {
    logic [4:0]  op;
    logic [1:0]  w;
    logic [63:0] a;
    logic [63:0] b;
    logic [7:0]  imm;
    logic [63:0] exp;
    logic [7:0]  req;
  } vec_t;

  // Operand a goes to k1, b to k2, the result lands in k3 (read back at 64 bits).
  localparam vec_t VECS [19] = '{
    '{5'd0,  2'd0, 64'hFFFF_FFFF_FFFF_FF01, 64'h0000_0000_0000_00FF, 8'd0,   64'h0,                   8'd4},  // R4 wrap 8
    '{5'd0,  2'd1, 64'h0000_0000_0001_8000, 64'h0000_0000_0000_8001, 8'd0,   64'h1,                   8'd1},  // R1 bit16 ignored
    '{5'd0,  2'd3, 64'hFFFF_FFFF_FFFF_FFFF, 64'h2,                   8'd0,   64'h1,                   8'd4},  // R4 wrap 64
    '{5'd1,  2'd2, 64'hFFFF_FFFF_FF00_FF00, 64'hFFFF_FFFF_0F0F_0F0F, 8'd0,   64'h0F00_0F00,           8'd3},  // R3 AND
    '{5'd2,  2'd1, 64'h0000_0000_0000_00FF, 64'h0000_0000_FFFF_0F0F, 8'd0,   64'h0F00,                8'd3},  // R3 ANDN
    '{5'd3,  2'd0, 64'h0000_0000_0000_0101, 64'h0000_0000_0000_0080, 8'd0,   64'h81,                  8'd3},  // R3 OR
    '{5'd4,  2'd3, 64'hAAAA_AAAA_5555_5555, 64'hFFFF_FFFF_FFFF_FFFF, 8'd0,   64'h5555_5555_AAAA_AAAA, 8'd3},  // R3 XOR
    '{5'd5,  2'd0, 64'h0F,                  64'h3C,                  8'd0,   64'hCC,                  8'd3},  // R3 XNOR
    '{5'd6,  2'd1, 64'h1234,                64'h0,                   8'd0,   64'hEDCB,                8'd2},  // R2 NOT upper clear
    '{5'd7,  2'd0, 64'h3F,                  64'h0,                   8'd4,   64'hF0,                  8'd8},  // R8 SHL
    '{5'd8,  2'd1, 64'h0003_F000,           64'h0,                   8'd4,   64'h0F00,                8'd8},  // R8 SHR truncated
    '{5'd7,  2'd2, 64'hFFFF_FFFF,           64'h0,                   8'd32,  64'h0,                   8'd8},  // R8 count==width
    '{5'd8,  2'd3, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0,                   8'd200, 64'h0,                   8'd8},  // R8 count>width
    '{5'd7,  2'd3, 64'h1,                   64'h0,                   8'd63,  64'h8000_0000_0000_0000, 8'd8},  // R8 max count
    '{5'd8,  2'd0, 64'hFF,                  64'h0,                   8'd8,   64'h0,                   8'd8},  // R8 boundary 8
    '{5'd9,  2'd0, 64'h1AB,                 64'h2CD,                 8'd0,   64'hABCD,                8'd7},  // R7 unpack 8
    '{5'd9,  2'd1, 64'h1234,                64'h5678,                8'd0,   64'h1234_5678,           8'd7},  // R7 unpack 16
    '{5'd9,  2'd2, 64'hFFFF_FFFF_DEAD_BEEF, 64'h0123_4567,           8'd0,   64'hDEAD_BEEF_0123_4567, 8'd7},  // R7 unpack 32
    '{5'd12, 2'd0, 64'h1234_5678_9ABC_DEF0, 64'h0,                   8'd0,   64'hF0,                  8'd9}   // R9 move k
  };

  task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic issue(logic [4:0] op, logic [1:0] w, logic [IW-1:0] d, logic [IW-1:0] a,
                       logic [IW-1:0] b, logic [7:0] imm, logic [63:0] g, logic [63:0] m,
                       logic v = 1'b1);
    @(negedge clk);
    op_code = op; op_width = w; dst_idx = d; srca_idx = a; srcb_idx = b;
    imm8 = imm; gpr_in = g; mem_rdata = m; op_valid = v;
    @(negedge clk);
    op_valid = 1'b0;
  endtask

  task automatic load(logic [IW-1:0] idx, logic [63:0] val);
    issue(5'd13, 2'd3, idx, 0, 0, 0, val, 0);
  endtask

  task automatic read_reg(logic [IW-1:0] idx, output logic [63:0] val);
    issue(5'd15, 2'd3, 0, idx, 0, 0, 0, 0);
    val = gpr_out;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    logic [63:0] v;
    repeat (3) @(negedge clk);
    // R12 reset state
    check("R12 gpr_out", gpr_out, 0);
    check("R12 mem_wdata/mem_wr", {mem_wdata[62:0], mem_wr}, 0);
    check("R12 flags", {62'b0, zf, cf}, 0);
    rst_n = 1'b1;
    read_reg(5, v);
    check("R12 register zero", v, 0);

    // R11 op_valid low has no effect
    issue(5'd13, 2'd3, 4, 0, 0, 0, 64'hDEAD, 0, 1'b0);
    read_reg(4, v);
    check("R11 invalid ignored", v, 0);

    foreach (VECS[i]) begin
      load(1, VECS[i].a);
      load(2, VECS[i].b);
      load(3, 64'hFFFF_FFFF_FFFF_FFFF);
      issue(VECS[i].op, VECS[i].w, 3, 1, 2, VECS[i].imm, 0, 0);
      read_reg(3, v);
      check($sformatf("R%0d vector %0d", VECS[i].req, i), v, VECS[i].exp);
    end

    // R7 unpack at 64 bits leaves destination
    load(3, 64'h55);
    issue(5'd9, 2'd3, 3, 1, 2, 0, 0, 0);
    read_reg(3, v);
    check("R7 unpack64 no write", v, 64'h55);

    // R10 self XNOR
    load(6, 64'h1234_0000_0000_1234);
    issue(5'd5, 2'd1, 6, 6, 6, 0, 0, 0);
    read_reg(6, v);
    check("R10 xnor self 16", v, 64'hFFFF);
    issue(5'd5, 2'd3, 6, 6, 6, 0, 0, 0);
    read_reg(6, v);
    check("R10 xnor self 64", v, 64'hFFFF_FFFF_FFFF_FFFF);

    // R5 or-test
    load(1, 64'h0F00); load(2, 64'h00F0); load(3, 64'h77);
    issue(5'd10, 2'd0, 3, 1, 2, 0, 0, 0);
    check("R5 ortest mixed", {62'b0, zf, cf}, 2'b00);
    read_reg(3, v);
    check("R5 ortest no write", v, 64'h77);
    load(1, 64'h100); load(2, 64'h200);
    issue(5'd10, 2'd0, 3, 1, 2, 0, 0, 0);
    check("R5 ortest zero (R1 upper ignored)", {62'b0, zf, cf}, 2'b10);
    load(1, 64'h0F); load(2, 64'hF0);
    issue(5'd10, 2'd0, 3, 1, 2, 0, 0, 0);
    check("R5 ortest ones", {62'b0, zf, cf}, 2'b01);

    // R6 test
    issue(5'd11, 2'd0, 3, 1, 2, 0, 0, 0);
    check("R6 test disjoint", {62'b0, zf, cf}, 2'b10);
    load(1, 64'hFF); load(2, 64'h0F);
    issue(5'd11, 2'd0, 3, 1, 2, 0, 0, 0);
    check("R6 test covered", {62'b0, zf, cf}, 2'b01);
    read_reg(3, v);
    check("R6 test no write", v, 64'h77);

    // R11 flags untouched by a non-test op
    issue(5'd0, 2'd0, 3, 1, 2, 0, 0, 0);
    check("R11 flags hold", {62'b0, zf, cf}, 2'b01);

    // R9 moves
    issue(5'd14, 2'd1, 5, 0, 0, 0, 0, 64'hFFFF_FFFF_FFFF_ABCD);
    read_reg(5, v);
    check("R9 load mem 16", v, 64'hABCD);
    issue(5'd16, 2'd0, 0, 5, 0, 0, 0, 0);
    check("R9 store data", mem_wdata, 64'hCD);
    check("R9 store strobe", {63'b0, mem_wr}, 1);
    @(negedge clk);
    check("R9 strobe one cycle", {63'b0, mem_wr}, 0);
    issue(5'd15, 2'd1, 0, 5, 0, 0, 0, 0);
    check("R9 to gpr 16", gpr_out, 64'hABCD);
    issue(5'd13, 2'd1, 7, 0, 0, 0, 64'hFFFF_1234, 0);
    read_reg(7, v);
    check("R9 from gpr 16", v, 64'h1234);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule